// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This block fetches one source operand for an arithmetic instruction. Alongside a start pulse it receives a 4-bit addressing-mode code, an instruction constant, the contents of a base register and an index register, the base register's number, and a 2-bit scale code. From these it either returns a value at once, or issues one or two reads on a synchronous memory port with one-cycle read latency and returns the data read. For the post-increment and pre-decrement style modes it also produces a write-back strobe carrying the updated base register. Instruction decode, the ALU and the register file storage are outside the block.

The sequencer has three states. In `ST_IDLE` the block accepts a request. For register, immediate and illegal codes it finishes in one cycle (transition *idle-finish*). For modes that need one read it issues the read from the request inputs and moves to `ST_FETCH` (transition *idle-to-fetch*). For memory-indirect it issues the pointer read and moves to `ST_PTR` (transition *idle-to-pointer*). `ST_PTR` uses the returned pointer as the address of a second read and moves to `ST_FETCH` (transition *pointer-to-fetch*). `ST_FETCH` captures the read data as the operand and returns to `ST_IDLE` (transition *fetch-to-idle*). `busy` is high in every state except `ST_IDLE`.

Top module: `opnd_resolver`

## Requirements
- R1: Mode code 0 returns `rb_val` on `opnd_data` with `opnd_valid` one cycle after the start edge, and no memory read.
- R2: Mode code 1 returns `konst` with `opnd_valid` one cycle after the start edge, and no memory read.
- R3: Mode code 2 makes exactly one read at `konst + rb_val` (modulo 2^W). The read data appears with `opnd_valid` two cycles after the start edge.
- R4: Mode code 3 reads at `rb_val`, and mode code 5 reads at `konst`. Each makes exactly one read and has two-cycle latency.
- R5: Mode code 4 makes exactly one read at `rb_val + rx_val`, with two-cycle latency.
- R6: Mode code 9 reads at `konst + rb_val + (rx_val << scale)`. Scale codes 0, 1, 2 and 3 select factors 1, 2, 4 and 8. Latency is two cycles.
- R7: Mode code 6 first reads at `rb_val`, then reads at the returned word. The second word is the operand, with `opnd_valid` three cycles after the start edge.
- R8: Mode code 7 makes one read at `rb_val`. In the same cycle as `opnd_valid` it raises `wb_en` with `wb_idx = rb_idx` and `wb_data = rb_val + 1`, wrapping modulo 2^W.
- R9: Mode code 8 behaves like R8, except that `wb_data = rb_val - 1` (modulo 2^W).
- R10: `wb_en` is raised only together with `opnd_valid`, and only for mode codes 7 and 8.
- R11: Mode codes 10 to 15 raise `illegal` for one cycle, one cycle after the start edge. They raise no `opnd_valid`, make no read and produce no write-back.
- R12: `start` is ignored while `busy` is high, and `busy` is low in the cycle that carries `opnd_valid`. The ignored request makes no read and changes neither the operand nor its timing.
- R13: While reset is held, `opnd_valid`, `illegal`, `wb_en`, `busy` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| mode | input | 4 | Addressing-mode code |
| konst | input | W | Displacement, immediate or absolute address |
| rb_idx | input | RI | Base register number |
| rb_val | input | W | Base register contents |
| rx_val | input | W | Index register contents |
| scale | input | 2 | Index scale code (shift amount) |
| busy | output | 1 | Request in flight |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | W | Memory read address |
| mem_rdata | input | W | Read data, valid the cycle after `mem_re` |
| opnd_valid | output | 1 | Operand ready, one-cycle pulse |
| opnd_data | output | W | Resolved operand |
| wb_en | output | 1 | Base register write-back strobe |
| wb_idx | output | RI | Register to write back |
| wb_data | output | W | Updated base value |
| illegal | output | 1 | Unknown mode code, one-cycle pulse |

## Verification
A sequencer stuck in or skipping `ST_PTR` shows up on the next memory-indirect request. The read count or the second read address is wrong, or the operand arrives a cycle early or late, which is visible within three cycles of the start edge. Stale latched write-back state shows as a `wb_en` pulse, or a wrong `wb_idx` or `wb_data`, in the same cycle as the operand. A wrong address sum or shift shows as a wrong `mem_addr` in the start cycle itself. Each request is checked for latency, read count, each read address, operand value and write-back fields.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
    typedef enum logic [3:0] {
        M_REG  = 4'd0,
        M_IMM  = 4'd1,
        M_DISP = 4'd2,
        M_IND  = 4'd3,
        M_IDX  = 4'd4,
        M_DIR  = 4'd5,
        M_MIND = 4'd6,
        M_AINC = 4'd7,
        M_ADEC = 4'd8,
        M_SCL  = 4'd9
    } amode_e;

    // How many memory reads a mode needs
    typedef enum logic [1:0] {
        K_NOMEM = 2'd0,
        K_ONE   = 2'd1,
        K_TWO   = 2'd2,
        K_BAD   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PTR   = 2'd1,
        ST_FETCH = 2'd2
    } seq_st_e;
endpackage

// File: rtl/opnd_agen.sv
module opnd_agen
    import opnd_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 2
) (
    input  logic [3:0]    mode,
    input  logic [W-1:0]  konst,
    input  logic [W-1:0]  rb,
    input  logic [W-1:0]  rx,
    input  logic [SW-1:0] scale,
    output logic [W-1:0]  addr,
    output logic [W-1:0]  direct_val,
    output logic [W-1:0]  upd_val,
    output logic          upd,
    output kind_e         kind
);
    logic [W-1:0] rx_scaled;

    always_comb begin
        rx_scaled = rx << scale;
    end

    always_comb begin
        addr       = rb;
        direct_val = rb;
        upd_val    = rb;
        upd        = 1'b0;
        kind       = K_BAD;
        case (mode)
            M_REG:  begin kind = K_NOMEM; direct_val = rb;    end
            M_IMM:  begin kind = K_NOMEM; direct_val = konst; end
            M_DISP: begin kind = K_ONE;   addr = konst + rb;  end
            M_IND:  begin kind = K_ONE;   addr = rb;          end
            M_IDX:  begin kind = K_ONE;   addr = rb + rx;     end
            M_DIR:  begin kind = K_ONE;   addr = konst;       end
            M_MIND: begin kind = K_TWO;   addr = rb;          end
            M_AINC: begin
                kind    = K_ONE;
                addr    = rb;
                upd     = 1'b1;
                upd_val = rb + W'(1);
            end
            M_ADEC: begin
                kind    = K_ONE;
                addr    = rb;
                upd     = 1'b1;
                upd_val = rb - W'(1);
            end
            M_SCL:  begin kind = K_ONE;   addr = konst + rb + rx_scaled; end
            default: kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
    import opnd_pkg::*;
#(
    parameter int W  = 16,
    parameter int RI = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  kind_e         kind,
    input  logic [W-1:0]  addr,
    input  logic [W-1:0]  direct_val,
    input  logic          upd,
    input  logic [W-1:0]  upd_val,
    input  logic [RI-1:0] rb_idx,
    input  logic [W-1:0]  mem_rdata,
    output logic          busy,
    output logic          mem_re,
    output logic [W-1:0]  mem_addr,
    output logic          opnd_valid,
    output logic [W-1:0]  opnd_data,
    output logic          wb_en,
    output logic [RI-1:0] wb_idx,
    output logic [W-1:0]  wb_data,
    output logic          illegal
);
    seq_st_e       state, nxt;
    logic          accept;
    logic          upd_q;
    logic [W-1:0]  upd_val_q;
    logic [RI-1:0] idx_q;

    assign accept = start && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (kind == K_ONE)      nxt = ST_FETCH;
                    else if (kind == K_TWO) nxt = ST_PTR;
                end
            end
            ST_PTR:   nxt = ST_FETCH;
            ST_FETCH: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Memory port: first read straight from the request, second from the pointer
    always_comb begin
        mem_re   = 1'b0;
        mem_addr = addr;
        unique case (state)
            ST_IDLE:  mem_re = accept && ((kind == K_ONE) || (kind == K_TWO));
            ST_PTR: begin
                mem_re   = 1'b1;
                mem_addr = mem_rdata;
            end
            ST_FETCH: mem_re = 1'b0;
            default:  mem_re = 1'b0;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_valid <= 1'b0;
            opnd_data  <= '0;
            wb_en      <= 1'b0;
            wb_idx     <= '0;
            wb_data    <= '0;
            illegal    <= 1'b0;
            upd_q      <= 1'b0;
            upd_val_q  <= '0;
            idx_q      <= '0;
        end else begin
            opnd_valid <= 1'b0;
            wb_en      <= 1'b0;
            illegal    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        upd_q     <= upd;
                        upd_val_q <= upd_val;
                        idx_q     <= rb_idx;
                        if (kind == K_NOMEM) begin
                            opnd_valid <= 1'b1;
                            opnd_data  <= direct_val;
                        end else if (kind == K_BAD) begin
                            illegal <= 1'b1;
                        end
                    end
                end
                ST_PTR: ;
                ST_FETCH: begin
                    opnd_valid <= 1'b1;
                    opnd_data  <= mem_rdata;
                    wb_en      <= upd_q;
                    wb_idx     <= idx_q;
                    wb_data    <= upd_val_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
    import opnd_pkg::*;
#(
    parameter int W  = 16,
    parameter int RI = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [W-1:0]  konst,
    input  logic [RI-1:0] rb_idx,
    input  logic [W-1:0]  rb_val,
    input  logic [W-1:0]  rx_val,
    input  logic [1:0]    scale,
    output logic          busy,
    output logic          mem_re,
    output logic [W-1:0]  mem_addr,
    input  logic [W-1:0]  mem_rdata,
    output logic          opnd_valid,
    output logic [W-1:0]  opnd_data,
    output logic          wb_en,
    output logic [RI-1:0] wb_idx,
    output logic [W-1:0]  wb_data,
    output logic          illegal
);
    localparam int SW = 2;

    logic [W-1:0] ag_addr, ag_direct, ag_upd_val;
    logic         ag_upd;
    kind_e        ag_kind;

    opnd_agen #(.W(W), .SW(SW)) u_agen (
        .mode       (mode),
        .konst      (konst),
        .rb         (rb_val),
        .rx         (rx_val),
        .scale      (scale),
        .addr       (ag_addr),
        .direct_val (ag_direct),
        .upd_val    (ag_upd_val),
        .upd        (ag_upd),
        .kind       (ag_kind)
    );

    opnd_seq #(.W(W), .RI(RI)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .kind       (ag_kind),
        .addr       (ag_addr),
        .direct_val (ag_direct),
        .upd        (ag_upd),
        .upd_val    (ag_upd_val),
        .rb_idx     (rb_idx),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .opnd_valid (opnd_valid),
        .opnd_data  (opnd_data),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .illegal    (illegal)
    );
endmodule

// File: rtl/opnd_chk.sv
module opnd_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [3:0]   mode,
    input logic [W-1:0] konst,
    input logic [W-1:0] rb_val,
    input logic         busy,
    input logic         mem_re,
    input logic [W-1:0] mem_addr,
    input logic         opnd_valid,
    input logic [W-1:0] opnd_data,
    input logic         wb_en,
    input logic         illegal
);
    // R1
    reg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd0) |=> (opnd_valid && opnd_data == $past(rb_val)));

    // R1
    reg_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd0) |-> !mem_re);

    // R2
    imm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd1) |=> (opnd_valid && opnd_data == $past(konst)));

    // R4
    ind_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd3) |-> (mem_re && mem_addr == rb_val));

    // R10
    wb_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> opnd_valid);

    // R11
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode > 4'd9) |=> (illegal && !opnd_valid && !wb_en));

    // R11
    illegal_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode > 4'd9) |-> !mem_re);

    // R12
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_valid |-> !busy);
endmodule

bind opnd_resolver opnd_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .konst      (konst),
    .rb_val     (rb_val),
    .busy       (busy),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .opnd_valid (opnd_valid),
    .opnd_data  (opnd_data),
    .wb_en      (wb_en),
    .illegal    (illegal)
);

// File: tb/test_opnd_resolver.sv
`timescale 1ns/1ps
module test_opnd_resolver;
    localparam int W  = 16;
    localparam int RI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [W-1:0]  konst = '0;
    logic [RI-1:0] rb_idx = '0;
    logic [W-1:0]  rb_val = '0;
    logic [W-1:0]  rx_val = '0;
    logic [1:0]    scale = '0;
    logic          busy, mem_re, opnd_valid, wb_en, illegal;
    logic [W-1:0]  mem_addr, opnd_data, wb_data;
    logic [W-1:0]  mem_rdata = '0;
    logic [RI-1:0] wb_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int nrd = 0;
    logic [W-1:0] rd_addr [4];

    opnd_resolver #(.W(W), .RI(RI)) i_opnd_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .konst(konst),
        .rb_idx(rb_idx), .rb_val(rb_val), .rx_val(rx_val), .scale(scale),
        .busy(busy), .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .opnd_valid(opnd_valid), .opnd_data(opnd_data), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal)
    );

    always #4 clk = ~clk;

    function automatic logic [W-1:0] mem_f(input logic [W-1:0] a);
        return (a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    // Memory model: one-cycle read latency, content computed from address
    always @(posedge clk) begin
        if (mem_re) begin
            if (nrd < 4) rd_addr[nrd] = mem_addr;
            nrd = nrd + 1;
            mem_rdata <= mem_f(mem_addr);
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp, input string what);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd5: return "R4";
            4'd4: return "R5";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            4'd9: return "R6";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [W-1:0] exp_addr(input logic [3:0] m, input logic [W-1:0] k,
            input logic [W-1:0] b, input logic [W-1:0] x, input logic [1:0] s);
        logic [W-1:0] factor;
        factor = W'(1) << s;
        case (m)
            4'd2: return k + b;
            4'd4: return b + x;
            4'd5: return k;
            4'd9: return k + b + W'(x * factor);
            default: return b;
        endcase
    endfunction

    task automatic run_op(input logic [3:0] m, input logic [W-1:0] k, input logic [W-1:0] b,
                          input logic [W-1:0] x, input logic [RI-1:0] ri, input logic [1:0] s);
        int lat;
        int exp_lat, exp_nrd;
        logic [W-1:0] exp_val, a0;
        bit exp_wb, exp_bad;
        string rq;
        rq = req_of(m);
        a0 = exp_addr(m, k, b, x, s);
        exp_bad = (m > 4'd9);
        exp_wb  = (m == 4'd7) || (m == 4'd8);
        if (m == 4'd0)      begin exp_lat = 1; exp_nrd = 0; exp_val = b; end
        else if (m == 4'd1) begin exp_lat = 1; exp_nrd = 0; exp_val = k; end
        else if (exp_bad)   begin exp_lat = 1; exp_nrd = 0; exp_val = '0; end
        else if (m == 4'd6) begin exp_lat = 3; exp_nrd = 2; exp_val = mem_f(mem_f(b)); end
        else                begin exp_lat = 2; exp_nrd = 1; exp_val = mem_f(a0); end

        @(negedge clk);
        start = 1'b1; mode = m; konst = k; rb_val = b; rx_val = x; rb_idx = ri; scale = s;
        nrd = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!opnd_valid && !illegal && lat < 6) begin
            @(negedge clk);
            lat = lat + 1;
        end
        chk(lat == exp_lat, rq, W'(lat), W'(exp_lat), "latency");
        if (exp_bad) begin
            chk(illegal && !opnd_valid, "R11", {15'd0, illegal}, 16'd1, "illegal flag");
        end else begin
            chk(opnd_valid && opnd_data == exp_val, rq, opnd_data, exp_val, "operand");
        end
        chk(nrd == exp_nrd, rq, W'(nrd), W'(exp_nrd), "read count");
        if (exp_nrd >= 1)
            chk(rd_addr[0] == a0, rq, rd_addr[0], a0, "first read address");
        if (exp_nrd == 2)
            chk(rd_addr[1] == mem_f(b), "R7", rd_addr[1], mem_f(b), "pointer read address");
        chk(wb_en == exp_wb, "R10", {15'd0, wb_en}, {15'd0, exp_wb}, "write-back strobe");
        if (exp_wb) begin
            chk(wb_idx == ri, rq, W'(wb_idx), W'(ri), "write-back index");
            chk(wb_data == ((m == 4'd7) ? b + W'(1) : b - W'(1)), rq, wb_data,
                (m == 4'd7) ? b + W'(1) : b - W'(1), "write-back value");
        end
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!opnd_valid && !illegal && !wb_en && !busy && !mem_re, "R13",
            {11'd0, opnd_valid, illegal, wb_en, busy, mem_re}, 16'd0, "reset outputs");
        rst_n = 1'b1;

        // Directed corners
        run_op(4'd0, 16'h1111, 16'hBEEF, 16'h0002, 4'd3, 2'd0);  // R1
        run_op(4'd1, 16'hCAFE, 16'h0001, 16'h0002, 4'd3, 2'd0);  // R2
        run_op(4'd2, 16'hFFF0, 16'h0020, 16'h0000, 4'd1, 2'd0);  // R3 wrap
        run_op(4'd3, 16'h0000, 16'h0400, 16'h0000, 4'd1, 2'd0);  // R4
        run_op(4'd5, 16'h7777, 16'h0400, 16'h0000, 4'd1, 2'd0);  // R4
        run_op(4'd4, 16'h0000, 16'h0100, 16'h0023, 4'd1, 2'd0);  // R5
        for (int s = 0; s < 4; s++)
            run_op(4'd9, 16'h1000, 16'h0010, 16'h0003, 4'd2, 2'(s));  // R6
        run_op(4'd6, 16'h0000, 16'h0042, 16'h0000, 4'd5, 2'd0);  // R7
        run_op(4'd7, 16'h0000, 16'hFFFF, 16'h0000, 4'd9, 2'd0);  // R8 wrap to 0
        run_op(4'd8, 16'h0000, 16'h0000, 16'h0000, 4'd6, 2'd0);  // R9 wrap to FFFF
        run_op(4'd10, 16'h0000, 16'h0001, 16'h0000, 4'd6, 2'd0); // R11
        run_op(4'd15, 16'h0000, 16'h0001, 16'h0000, 4'd6, 2'd0); // R11

        // R12: second start while busy is ignored
        @(negedge clk);
        start = 1'b1; mode = 4'd2; konst = 16'h0100; rb_val = 16'h0005; rx_val = '0;
        rb_idx = 4'd2; scale = 2'd0; nrd = 0;
        @(negedge clk);
        chk(busy, "R12", {15'd0, busy}, 16'd1, "busy after read start");
        mode = 4'd0; rb_val = 16'h1234;
        @(negedge clk);
        start = 1'b0;
        chk(opnd_valid && opnd_data == mem_f(16'h0105), "R12", opnd_data,
            mem_f(16'h0105), "operand unaffected by ignored start");
        chk(!busy, "R12", {15'd0, busy}, 16'd0, "idle with operand");
        @(negedge clk);
        chk(!opnd_valid, "R12", {15'd0, opnd_valid}, 16'd0, "no extra operand");
        chk(nrd == 1, "R12", W'(nrd), 16'd1, "ignored start made no read");

        // Constrained random mix, all mode codes
        for (int i = 0; i < 400; i++) begin
            run_op(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
                   16'($urandom), 4'($urandom), 2'($urandom));
        end
        repeat (2) @(negedge clk);
        summary();
    end
endmodule